// File: doc/BRIEF.md
# Bridge Configuration Status Register

This block holds the 16-bit status word of a bus bridge's primary-side configuration space. Single-cycle event strobes from the bus engine set sticky error flags. Some of these strobes count only when qualifying conditions hold in the same cycle, namely an enable bit from the command register or ownership of the bus. Software reads the word and clears chosen flags by writing ones to them. Only bytes whose byte enable is asserted take part in a clear.

The read value combines the six sticky flags with fields that never change. A two-bit device-select timing code is fixed at medium speed. A capabilities-present bit is fixed at one. All other bits read zero. Reading has no side effects. The read value follows the flag registers combinationally, so a flag set at a clock edge is visible right after that edge.

Top module: `cfgstat_top`

## Requirements
- R1: While reset is asserted and right after it, the read value is 16'h0210.
- R2: A pulse on `ev_parity` sets bit 15 whatever the command enables and bus ownership are.
- R3: A pulse on `ev_serr` sets bit 14 only if `serr_en` is 1 in the same cycle. Otherwise bit 14 keeps its value.
- R4: A pulse on `ev_mabort_rx` sets bit 13, and a pulse on `ev_tabort_rx` sets bit 12.
- R5: A pulse on `ev_tabort_tx` sets bit 11.
- R6: Bit 8 is set only when `ev_perr`, `bus_master` and `perr_resp_en` are all 1 in the same cycle. If any one of them is 0, bit 8 keeps its value.
- R7: A write with `wr_be[1]`=1 clears every flag among bits 15:11 and 8 whose `wr_data` bit is 1. Flags whose data bit is 0 keep their value.
- R8: A write with `wr_be[1]`=0 clears no flag, whatever the data.
- R9: If a set event and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R10: Bits 10:9 always read 2'b01 and bit 4 always reads 1. Bits 7:5 and 3:0 always read 0. Writes do not change any of these bits.
- R11: With no event and no write, every flag holds its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released in step with the clock. |
| ev_parity | input | 1 | Parity error detected (pulse) |
| ev_serr | input | 1 | Bridge signalled a system error (pulse) |
| ev_mabort_rx | input | 1 | Bridge-initiated cycle ended in a master abort (pulse) |
| ev_tabort_rx | input | 1 | Bridge-initiated cycle ended in a target abort (pulse) |
| ev_tabort_tx | input | 1 | Bridge ended a transaction with a target abort (pulse) |
| ev_perr | input | 1 | Data parity error line observed asserted (pulse) |
| serr_en | input | 1 | System-error enable from the command register |
| perr_resp_en | input | 1 | Parity-error response enable from the command register |
| bus_master | input | 1 | The bridge owns the bus for the current data phase |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 16 | Write data; a 1 clears the matching flag |
| wr_be | input | 2 | Byte enables, bit 1 covers bits 15:8 |
| rd_data | output | 16 | Current read value |

## Verification
Each event strobe is first applied alone, so that a wrong bit position or a missing event shows up. The qualified flags then see every combination that leaves out exactly one condition, which separates a correct AND of the conditions from a partial one. Clears are tried with single-bit and all-ones data, with the upper byte enable on and off, and in the same cycle as a set. This tells clear-priority from set-priority and shows whether the byte gate is honoured. An all-ones write over the fixed fields confirms that they cannot be written.

// File: rtl/cfgstat_pkg.sv
package cfgstat_pkg;
  localparam int REG_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int BE_W      = REG_W / BYTE_W;
  localparam int NUM_FLAGS = 6;

  // Flag slots: 0 parity, 1 system error, 2 master abort rx,
  // 3 target abort rx, 4 target abort tx, 5 data parity (master)
  localparam int FLAG_POS [NUM_FLAGS] = '{15, 14, 13, 12, 11, 8};

  // Constant part of the word: timing code 01 at 10:9, capability bit 4
  localparam logic [REG_W-1:0] FIXED_VAL = 16'h0210;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/cfgstat_qualify.sv
module cfgstat_qualify
  import cfgstat_pkg::*;
(
  input  logic      ev_parity,
  input  logic      ev_serr,
  input  logic      ev_mabort_rx,
  input  logic      ev_tabort_rx,
  input  logic      ev_tabort_tx,
  input  logic      ev_perr,
  input  logic      serr_en,
  input  logic      perr_resp_en,
  input  logic      bus_master,
  output flag_vec_t set_vec
);
  always_comb begin
    set_vec    = '0;
    set_vec[0] = ev_parity;
    set_vec[1] = ev_serr & serr_en;
    set_vec[2] = ev_mabort_rx;
    set_vec[3] = ev_tabort_rx;
    set_vec[4] = ev_tabort_tx;
    set_vec[5] = ev_perr & bus_master & perr_resp_en;
  end
endmodule

// File: rtl/cfgstat_clear.sv
module cfgstat_clear
  import cfgstat_pkg::*;
(
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [BE_W-1:0]  wr_be,
  output flag_vec_t        clr_vec
);
  // Some data bits and byte lanes carry no flag
  logic unused_wr;
  assign unused_wr = &{1'b0, wr_data, wr_be};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
    localparam int POS  = FLAG_POS[i];
    localparam int LANE = POS / BYTE_W;
    assign clr_vec[i] = wr_en & wr_be[LANE] & wr_data[POS];
  end
endmodule

// File: rtl/cfgstat_flag.sv
module cfgstat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic upd;
  logic nxt;

  // Set takes priority over a simultaneous clear
  always_comb begin
    upd = set_i | clr_i;
    nxt = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_o <= 1'b0;
    else if (upd) q_o <= nxt;
  end
endmodule

// File: rtl/cfgstat_top.sv
module cfgstat_top
  import cfgstat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_parity,
  input  logic             ev_serr,
  input  logic             ev_mabort_rx,
  input  logic             ev_tabort_rx,
  input  logic             ev_tabort_tx,
  input  logic             ev_perr,
  input  logic             serr_en,
  input  logic             perr_resp_en,
  input  logic             bus_master,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [BE_W-1:0]  wr_be,
  output logic [REG_W-1:0] rd_data
);
  flag_vec_t set_vec;
  flag_vec_t clr_vec;
  flag_vec_t flag_q;

  cfgstat_qualify u_qual (
    .ev_parity    (ev_parity),
    .ev_serr      (ev_serr),
    .ev_mabort_rx (ev_mabort_rx),
    .ev_tabort_rx (ev_tabort_rx),
    .ev_tabort_tx (ev_tabort_tx),
    .ev_perr      (ev_perr),
    .serr_en      (serr_en),
    .perr_resp_en (perr_resp_en),
    .bus_master   (bus_master),
    .set_vec      (set_vec)
  );

  cfgstat_clear u_clr (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .clr_vec (clr_vec)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    cfgstat_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (flag_q[i])
    );
  end

  always_comb begin
    rd_data = FIXED_VAL;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      rd_data[FLAG_POS[i]] = flag_q[i];
    end
  end
endmodule

// File: rtl/cfgstat_chk.sv
module cfgstat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_parity,
  input logic        ev_serr,
  input logic        ev_mabort_rx,
  input logic        ev_tabort_rx,
  input logic        ev_tabort_tx,
  input logic        ev_perr,
  input logic        serr_en,
  input logic        perr_resp_en,
  input logic        bus_master,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [1:0]  wr_be,
  input logic [15:0] rd_data
);
  assert_reset_val_R1: assert property (@(posedge clk)
    !rst_n |-> rd_data == 16'h0210);

  assert_parity_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_parity |=> rd_data[15]);

  assert_serr_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[14] && !(ev_serr && serr_en)) |=> !rd_data[14]);

  assert_mabort_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mabort_rx |=> rd_data[13]);

  assert_tabort_tx_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tabort_tx |=> rd_data[11]);

  assert_dperr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[8] && !(ev_perr && bus_master && perr_resp_en)) |=> !rd_data[8]);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_data[13] && !ev_mabort_rx) |=> !rd_data[13]);

  assert_lane_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[12] && !(wr_en && wr_be[1])) |=> rd_data[12]);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tabort_rx && wr_en && wr_be[1] && wr_data[12]) |=> rd_data[12]);

  assert_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[10:9] == 2'b01 && rd_data[4] && rd_data[7:5] == 3'b000
    && rd_data[3:0] == 4'h0);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ev_parity) |=> rd_data[15] == $past(rd_data[15]));
endmodule

bind cfgstat_top cfgstat_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_parity    (ev_parity),
  .ev_serr      (ev_serr),
  .ev_mabort_rx (ev_mabort_rx),
  .ev_tabort_rx (ev_tabort_rx),
  .ev_tabort_tx (ev_tabort_tx),
  .ev_perr      (ev_perr),
  .serr_en      (serr_en),
  .perr_resp_en (perr_resp_en),
  .bus_master   (bus_master),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .wr_be        (wr_be),
  .rd_data      (rd_data)
);

// File: tb/sim_cfgstat_top.sv
`timescale 1ns/1ps
module sim_cfgstat_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_parity, ev_serr, ev_mabort_rx, ev_tabort_rx, ev_tabort_tx, ev_perr;
  logic        serr_en, perr_resp_en, bus_master;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [1:0]  wr_be;
  logic [15:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] model_flags = 16'h0000;
  localparam logic [15:0] FLAG_MASK = 16'hF900;
  localparam logic [15:0] FIXED     = 16'h0210;

  always #2 clk = ~clk;

  cfgstat_top u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_parity(ev_parity), .ev_serr(ev_serr), .ev_mabort_rx(ev_mabort_rx),
    .ev_tabort_rx(ev_tabort_rx), .ev_tabort_tx(ev_tabort_tx), .ev_perr(ev_perr),
    .serr_en(serr_en), .perr_resp_en(perr_resp_en), .bus_master(bus_master),
    .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be), .rd_data(rd_data)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
    end
  endtask

  // ev = {parity, serr, mabort_rx, tabort_rx, tabort_tx, perr}
  // ctl = {serr_en, perr_resp_en, bus_master}
  task automatic step(input logic [5:0] ev, input logic [2:0] ctl, input logic we,
                      input logic [15:0] d, input logic [1:0] be, input string tag);
    logic [15:0] setv;
    logic [15:0] clrv;
    @(negedge clk);
    {ev_parity, ev_serr, ev_mabort_rx, ev_tabort_rx, ev_tabort_tx, ev_perr} = ev;
    {serr_en, perr_resp_en, bus_master} = ctl;
    wr_en = we; wr_data = d; wr_be = be;
    setv = 16'h0000;
    setv[15] = ev[5];
    setv[14] = ev[4] & ctl[2];
    setv[13] = ev[3];
    setv[12] = ev[2];
    setv[11] = ev[1];
    setv[8]  = ev[0] & ctl[0] & ctl[1];
    clrv = (we && be[1]) ? (d & FLAG_MASK) : 16'h0000;
    model_flags = setv | (model_flags & ~clrv);
    exp_q.push_back(model_flags | FIXED);
    tag_q.push_back(tag);
  endtask

  // Monitor: one item per clock, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rd_data, e, t);
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected<=5000", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    {ev_parity, ev_serr, ev_mabort_rx, ev_tabort_rx, ev_tabort_tx, ev_perr} = '0;
    {serr_en, perr_resp_en, bus_master} = '0;
    wr_en = 1'b0; wr_data = '0; wr_be = '0;
    repeat (3) @(negedge clk);
    check(rd_data, 16'h0210, "R1 in reset");
    rst_n = 1'b1;
    step(6'b0, 3'b000, 1'b0, 16'h0, 2'b00, "R1 after reset");
    // R2: parity, unconditional
    step(6'b100000, 3'b000, 1'b0, 16'h0, 2'b00, "R2 parity");
    step(6'b0, 3'b000, 1'b0, 16'h0, 2'b00, "R11 hold");
    // R3: serr gated by enable
    step(6'b010000, 3'b000, 1'b0, 16'h0, 2'b00, "R3 serr disabled");
    step(6'b010000, 3'b100, 1'b0, 16'h0, 2'b00, "R3 serr enabled");
    // R4 / R5
    step(6'b001000, 3'b000, 1'b0, 16'h0, 2'b00, "R4 master abort");
    step(6'b000100, 3'b000, 1'b0, 16'h0, 2'b00, "R4 target abort rx");
    step(6'b000010, 3'b000, 1'b0, 16'h0, 2'b00, "R5 target abort tx");
    // R6: every single missing condition, then all three
    step(6'b000001, 3'b010, 1'b0, 16'h0, 2'b00, "R6 no master");
    step(6'b000001, 3'b001, 1'b0, 16'h0, 2'b00, "R6 no response enable");
    step(6'b000000, 3'b011, 1'b0, 16'h0, 2'b00, "R6 no perr");
    step(6'b000001, 3'b011, 1'b0, 16'h0, 2'b00, "R6 all conditions");
    // R8: lane disabled
    step(6'b0, 3'b000, 1'b1, 16'hFFFF, 2'b01, "R8 upper lane off");
    // R7: single-bit clear, then zero write
    step(6'b0, 3'b000, 1'b1, 16'h2000, 2'b10, "R7 clear bit13");
    step(6'b0, 3'b000, 1'b1, 16'h0000, 2'b11, "R7 zero write");
    step(6'b0, 3'b000, 1'b1, 16'h0100, 2'b10, "R7 clear bit8");
    // R9: set and clear same cycle
    step(6'b000100, 3'b000, 1'b1, 16'h1000, 2'b10, "R9 set wins");
    // R10: all-ones write clears flags but not fixed fields
    step(6'b0, 3'b000, 1'b1, 16'hFFFF, 2'b11, "R10 fixed fields");
    step(6'b0, 3'b000, 1'b1, 16'h06F0, 2'b11, "R10 write fixed only");
    step(6'b111111, 3'b111, 1'b0, 16'h0, 2'b00, "R2 all events");
    step(6'b0, 3'b000, 1'b0, 16'h0, 2'b00, "R11 hold all");
    step(6'b0, 3'b000, 1'b1, 16'hF900, 2'b11, "R7 clear all");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule